// File: doc/BRIEF.md
# Lockable Clock-Enable Prescaler

This block slows the effective rate of downstream logic without touching the clock tree. It emits a one-cycle enable strobe, `tick_o`, which downstream registers use as a qualifier on the full-rate clock. Software programs the block through a single 8-bit control register. The register holds an enable flag and a 7-bit select value `d`. While the flag is set, the strobe fires once every `129 - d` source cycles, so the period ranges from 2 to 129. While the flag is clear, the strobe is high on every cycle.

The select value is protected by an acceptance rule. It is loaded only by the write that raises the enable flag from 0. It cannot be changed while division is running. A write that clears the flag turns division off and leaves the stored select value as it was. The register is readable at all times through `rd_data_o`, which shows the current flag and the last select value that was accepted.

Top module: `clkdiv_lock`

## Requirements
- R1: After reset, `rd_data_o` reads 0x00 and `tick_o` is high.
- R2: While the enable flag (`rd_data_o[7]`) is 0, `tick_o` is high on every cycle.
- R3: A write with `wr_data_i[7]`=1 while the flag is 0 sets the flag and stores `wr_data_i[6:0]` as `d`. After that clock edge, `rd_data_o` equals the written byte.
- R4: While the flag is 1, `tick_o` is high for exactly one cycle out of every `129 - d` cycles.
- R5: After an enabling write, `tick_o` is low for `128 - d` cycles and is first high in cycle `129 - d`. Cycle 1 is the cycle that follows the edge that accepted the write.
- R6: While the flag is 1, a write with `wr_data_i[7]`=1 changes neither `d` nor the strobe phase.
- R7: A write with `wr_data_i[7]`=0 clears the flag, discards `wr_data_i[6:0]` and keeps the stored `d`. `rd_data_o` then reads `{1'b0, d}`.
- R8: In the cycle after a clearing write, `tick_o` is high. A later enabling write restarts the count from zero.
- R9: The extreme select values give the extreme periods: d=127 gives a period of 2 and d=0 gives a period of 129.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data: bit 7 is the enable flag, bits 6..0 are the select value |
| rd_data_o | output | 8 | Register readback: current flag and accepted select value |
| tick_o | output | 1 | Clock-enable strobe |

## Verification
The interesting collision is a register write that lands in the same cycle as a strobe. Two such cases are provoked. In the first, a clearing write is made in a strobe cycle: the counter must not wrap into a stale phase, and the strobe must stay high on the next cycle. In the second, a keep-enabled write is made in a strobe cycle: the counter wrap must proceed as though no write had happened. The bench waits until `tick_o` is observed high and then drives the write so that the write lands on the same clock edge. A behavioural model counts the phase position within the period and judges `tick_o` and `rd_data_o` on every cycle.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int unsigned SEL_W = 7;
  localparam int unsigned REG_W = SEL_W + 1;
  localparam int unsigned CNT_W = SEL_W + 1;
  // period = PER_BASE - d
  localparam int unsigned PER_BASE = (1 << SEL_W) + 1;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
  } ctrl_t;
endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output ctrl_t            ctrl_o
);
  ctrl_t ctrl_q, ctrl_d;
  logic  wr_en_bit;
  logic  [SEL_W-1:0] wr_sel;

  assign wr_en_bit = wr_data_i[REG_W-1];
  assign wr_sel    = wr_data_i[SEL_W-1:0];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en_i) begin
      if (!wr_en_bit) begin
        ctrl_d.en = 1'b0;            // select field rejected
      end else if (!ctrl_q.en) begin
        ctrl_d.en  = 1'b1;
        ctrl_d.sel = wr_sel;         // only load point for the select
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

  assert_latch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_en_bit && !ctrl_q.en) |=> (ctrl_q.en && ctrl_q.sel == $past(wr_sel)));

  assert_sel_locked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.en && !(wr_en_i && !wr_en_bit)) |=> (ctrl_q.en && $stable(ctrl_q.sel)));

  assert_reject_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_en_bit) |=> (!ctrl_q.en && $stable(ctrl_q.sel)));
endmodule

// File: rtl/clkdiv_tick.sv
module clkdiv_tick
  import clkdiv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam logic [CNT_W-1:0] LAST_BASE = CNT_W'(PER_BASE - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic             wrap;

  assign last = LAST_BASE - {1'b0, sel_i};
  assign wrap = (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;   // held while bypassed
    else if (wrap)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = !en_i || wrap;

  assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q <= last));

  assert_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_i) |-> (cnt_q == '0));

  assert_bypass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_i) |-> tick_o);
endmodule

// File: rtl/clkdiv_lock.sv
module clkdiv_lock
  import clkdiv_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  output logic       tick_o
);
  ctrl_t ctrl;

  clkdiv_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .ctrl_o    (ctrl)
  );

  clkdiv_tick u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ctrl.en),
    .sel_i  (ctrl.sel),
    .tick_o (tick_o)
  );

  assign rd_data_o = ctrl;

  assert_bypass_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[7] |-> tick_o);

  assert_min_period_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[7] && $past(rd_data_o[7]) && $past(tick_o)) |-> !tick_o);
endmodule

// File: tb/clkdiv_lock_bench.sv
module clkdiv_lock_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       tick;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cycles = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // behavioural reference
  bit m_en = 0;
  int m_d = 0;
  int m_phase = 0;

  always #5 clk = ~clk;

  clkdiv_lock u_clkdiv_lock (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data),
    .tick_o    (tick)
  );

  function automatic bit exp_tick();
    return !m_en || (m_phase == 129 - m_d);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_d = 0; m_phase = 0;
    end else begin
      bit t;
      t = exp_tick();
      if (wr_en && !wr_data[7]) m_en = 0;
      else if (wr_en && wr_data[7] && !m_en) begin
        m_en = 1; m_d = int'(wr_data[6:0]); m_phase = 1;
      end else if (m_en) m_phase = t ? 1 : m_phase + 1;
    end
  end

  task automatic check(string req, int act, int exp, string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      check(cur_req, int'(tick), int'(exp_tick()), "tick_o");
      check(cur_req, int'(rd_data), (int'(m_en) << 7) | m_d, "rd_data_o");
    end
    if (cycles > 100000 && !done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wr(logic [7:0] b);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_data = b;
    @(negedge clk); #1;
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  // drive a write so its edge coincides with a strobe cycle
  task automatic wr_on_tick(logic [7:0] b);
    do @(negedge clk); while (!tick);
    #1;
    wr_en = 1'b1; wr_data = b;
    @(negedge clk); #1;
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(2);
    #1 rst_n = 1'b1;
    @(negedge clk); #2;
    cur_req = "R1";
    check("R1", int'(rd_data), 0, "reset readback");
    check("R1", int'(tick), 1, "reset tick");
    cur_req = "R2"; idle(6);
    cur_req = "R3"; wr(8'h85);
    check("R3", int'(rd_data), 8'h85, "latched readback");
    cur_req = "R5"; idle(130);
    cur_req = "R4"; idle(200);
    cur_req = "R6"; wr(8'hE4); idle(150);
    wr_on_tick(8'hFF); idle(130);
    cur_req = "R7"; wr_on_tick(8'h4D);
    check("R7", int'(rd_data), 8'h05, "rejected select readback");
    cur_req = "R8"; idle(5);
    wr(8'h8A); idle(60); wr(8'h00); idle(3); wr(8'h8A); idle(260);
    cur_req = "R9"; wr(8'h00); wr(8'hFF); idle(20);
    wr(8'h00); wr(8'h80); idle(400);
    cur_req = "R7"; wr(8'h3C);
    check("R7", int'(rd_data), 8'h00, "d=0 kept after clear");
    idle(4);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule